// File: doc/BRIEF.md
# Interrupt Aggregator with Non-Maskable Select

This block collects interrupt request flags from many peripherals and presents them to a processor's interrupt controller as one 32-bit request vector. Each interrupt line may be shared by several sub-sources, such as several port banks or several PWM channels. The raw sub-source flags pass through a two-flop synchroniser into the core clock domain. The synchronised flags of a line are ORed together and set that line's bit in a request register. Software can read this register, and it can also use it to raise or drop interrupts for test.

For every line, a read-only identity register at byte offset 4·n shows which sub-sources of that line are currently asserting. Lines with no peripheral attached hold a plain read-write scratch word in that slot instead. A 5-bit select register chooses one of the 32 request bits. After one register stage, the chosen bit drives a separate non-maskable interrupt output. Software reaches all of this through a simple register bus: byte address, write enable, write data, and combinational read data.

Top module: `irqg_top`

## Requirements
- R1: After a synchronous reset, `irq_out` and `nmi_out` are 0, and the request register (0x84), the select register (0x80) and every slot at 4·n read 0.
- R2: For a line that is not reserved, reading offset 4·n returns the synchronised sub-source flags of line n in bits [SUB_W-1:0], with all other bits 0. The flags become readable after two rising edges. Writes to that offset are ignored.
- R3: A line whose synchronised sub-source flags are not all zero sets bit n of the request register on the third rising edge after the raw input is applied. The bit stays set on every edge while the flags stay nonzero.
- R4: Reserved lines are 16, 17, 19 to 27, 30 and 31 (mask 0xCFFB0000). On these lines, offset 4·n is a 32-bit read-write word that resets to 0. Their sub-source inputs never set a request bit and do not change the word.
- R5: Writing 1 to bit n of offset 0x84 while that bit is 0 sets it.
- R6: Writing 1 to bit n of offset 0x84 while that bit is 1 clears it. Writing 0 leaves the bit unchanged. With no write and no hardware request, the register holds its value.
- R7: If a line's synchronised request and a software clear of the same bit occur on the same edge, the bit stays 1.
- R8: Offset 0x80 holds a 5-bit select field in bits [4:0], and its upper bits read 0. At each edge, `nmi_out` takes the value of the request bit chosen by the select field at the previous edge.
- R9: An address with nonzero bits [1:0], or at or above 0x88, reads 0. A write to such an address changes no state.
- R10: `irq_out` equals the request register at all times, and a read of offset 0x84 returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| sub_req | input | 32·SUB_W | Raw sub-source flags; line n uses bits [n·SUB_W +: SUB_W] |
| irq_out | output | 32 | Request vector to the interrupt controller |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with SUB_W = 4 and the default reserved mask. With these values, the widest sub-source group (four PWM channels) is covered, and so are the reserved scratch slots next to live lines 18, 28 and 29. A behavioural model follows the two-edge synchroniser delay and the XOR-style toggle write, and the bench compares `irq_out` and `nmi_out` against it on every cycle. This comparison catches races between a held hardware request and a software clear. Directed reads cover unaligned and out-of-range addresses, attempts to write identity slots, and the select field's truncation of upper write bits.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
    localparam int LINES     = 32;
    localparam int REG_W     = 32;
    localparam int LINE_W    = $clog2(LINES);
    localparam int NMI_WORD  = LINES;
    localparam int PEND_WORD = LINES + 1;
    localparam int ADDR_W    = $clog2((PEND_WORD + 1) * 4);
    localparam int WORD_W    = ADDR_W - 2;

    typedef enum logic [1:0] {
        RGN_SRC  = 2'd0,
        RGN_SEL  = 2'd1,
        RGN_PEND = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef struct packed {
        region_e           rgn;
        logic [LINE_W-1:0] line;
    } decode_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        logic [WORD_W-1:0] w;
        w      = a[ADDR_W-1:2];
        d.line = w[LINE_W-1:0];
        if (a[1:0] != 2'b00)
            d.rgn = RGN_NONE;
        else if (int'(w) < LINES)
            d.rgn = RGN_SRC;
        else if (int'(w) == NMI_WORD)
            d.rgn = RGN_SEL;
        else if (int'(w) == PEND_WORD)
            d.rgn = RGN_PEND;
        else
            d.rgn = RGN_NONE;
        return d;
    endfunction
endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++)
                stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irqg_pending.sv
module irqg_pending #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [LINES-1:0] sw_toggle,
    input  logic [LINES-1:0] hw_set,
    output logic [LINES-1:0] q
);
    logic [LINES-1:0] flip;

    always_comb begin
        flip = sw_we ? sw_toggle : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= (q ^ flip) | hw_set;
    end
endmodule

// File: rtl/irqg_nmi.sv
module irqg_nmi #(
    parameter int LINES = 32,
    parameter int SEL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic [LINES-1:0] pend,
    output logic [SEL_W-1:0] sel,
    output logic             nmi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
            nmi <= 1'b0;
        end else begin
            nmi <= pend[sel];
            if (sel_we)
                sel <= sel_wdata;
        end
    end
endmodule

// File: rtl/irqg_top.sv
module irqg_top
    import irqg_pkg::*;
#(
    parameter int                SUB_W         = 4,
    parameter int                SYNC_STAGES   = 2,
    parameter logic [LINES-1:0]  RESERVED_MASK = 32'hCFFB_0000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [REG_W-1:0]         bus_wdata,
    output logic [REG_W-1:0]         bus_rdata,
    input  logic [LINES*SUB_W-1:0]   sub_req,
    output logic [LINES-1:0]         irq_out,
    output logic                     nmi_out
);
    localparam int SUB_BITS = LINES * SUB_W;

    decode_t                      dec;
    logic [SUB_BITS-1:0]          sub_sync;
    logic [LINES-1:0]             line_req;
    logic [LINES-1:0][REG_W-1:0]  slot_val;
    logic                         pend_we;
    logic                         sel_we;
    logic [LINE_W-1:0]            nmi_sel;
    logic [LINES-1:0]             pend_q;

    always_comb begin
        dec     = decode_addr(bus_addr);
        pend_we = bus_we && (dec.rgn == RGN_PEND);
        sel_we  = bus_we && (dec.rgn == RGN_SEL);
    end

    irqg_sync #(
        .W      (SUB_BITS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sub_req),
        .q   (sub_sync)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        if (RESERVED_MASK[n]) begin : g_resv
            logic [REG_W-1:0] scratch;
            logic             slot_we;
            logic [SUB_W-1:0] unused_sub;
            assign unused_sub = sub_sync[n*SUB_W +: SUB_W];
            assign slot_we    = bus_we && (dec.rgn == RGN_SRC) &&
                                (dec.line == LINE_W'(n));
            always_ff @(posedge clk) begin
                if (rst)
                    scratch <= '0;
                else if (slot_we)
                    scratch <= bus_wdata;
            end
            assign slot_val[n] = scratch;
            assign line_req[n] = 1'b0 & (|unused_sub);
        end else begin : g_live
            logic [SUB_W-1:0] flags;
            assign flags       = sub_sync[n*SUB_W +: SUB_W];
            assign slot_val[n] = REG_W'(flags);
            assign line_req[n] = |flags;
        end
    end

    irqg_pending #(
        .LINES (LINES)
    ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .sw_we     (pend_we),
        .sw_toggle (bus_wdata[LINES-1:0]),
        .hw_set    (line_req),
        .q         (pend_q)
    );

    irqg_nmi #(
        .LINES (LINES),
        .SEL_W (LINE_W)
    ) u_nmi (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (sel_we),
        .sel_wdata (bus_wdata[LINE_W-1:0]),
        .pend      (pend_q),
        .sel       (nmi_sel),
        .nmi       (nmi_out)
    );

    always_comb begin
        unique case (dec.rgn)
            RGN_SRC:  bus_rdata = slot_val[dec.line];
            RGN_SEL:  bus_rdata = REG_W'(nmi_sel);
            RGN_PEND: bus_rdata = REG_W'(pend_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_out = pend_q;
endmodule

// File: rtl/irqg_checker.sv
module irqg_checker
    import irqg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [LINES-1:0]  irq,
    input logic              nmi,
    input logic [LINE_W-1:0] sel,
    input logic              pend_we,
    input logic [REG_W-1:0]  wdata,
    input logic [LINES-1:0]  hw_set
);
    // R1: reset clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (irq == '0) && !nmi);

    // R5 and R6: toggle write with no hardware request
    a_r5_toggle_write: assert property (@(posedge clk) disable iff (rst)
        (pend_we && hw_set == '0) |=> irq == $past(irq ^ wdata[LINES-1:0]));

    // R6: no write, no request, no change
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!pend_we && hw_set == '0) |=> irq == $past(irq));

    // R7: hardware request always leaves its bit set
    a_r7_hw_priority: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> (irq & $past(hw_set)) == $past(hw_set));

    // R8: non-maskable output follows the selected bit one edge later
    a_r8_nmi_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> nmi == $past(irq[sel]));
endmodule

bind irqg_top irqg_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq     (irq_out),
    .nmi     (nmi_out),
    .sel     (nmi_sel),
    .pend_we (pend_we),
    .wdata   (bus_wdata),
    .hw_set  (line_req)
);

// File: tb/sim_irqg_top.sv
module sim_irqg_top;
    localparam int          SW   = 4;
    localparam logic [31:0] RESV = 32'hCFFB_0000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   addr = '0;
    logic         we = 1'b0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] sub = '0;
    logic [31:0]  irq;
    logic         nmi;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    irqg_top #(.SUB_W(SW), .RESERVED_MASK(RESV)) u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .sub_req(sub),
        .irq_out(irq), .nmi_out(nmi)
    );

    // behavioural reference model
    logic [31:0]  m_req, t_set;
    logic [31:0]  m_res [32];
    logic [4:0]   m_sel;
    logic         m_nmi, t_nmi;
    logic [127:0] m_s1, m_s2;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_req = '0; m_sel = '0; m_nmi = 1'b0; m_s1 = '0; m_s2 = '0;
            for (int i = 0; i < 32; i++) m_res[i] = '0;
        end else begin
            t_set = '0;
            for (int i = 0; i < 32; i++)
                if (!RESV[i] && m_s2[i*SW +: SW] != '0) t_set[i] = 1'b1;
            t_nmi = m_req[m_sel];
            if (we && addr == 8'h84) m_req = (m_req ^ wdata) | t_set;
            else                     m_req = m_req | t_set;
            if (we && addr == 8'h80) m_sel = wdata[4:0];
            if (we && addr < 8'h80 && addr[1:0] == 2'b00 && RESV[addr[6:2]])
                m_res[addr[6:2]] = wdata;
            m_nmi = t_nmi;
            m_s2  = m_s1;
            m_s1  = sub;
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a[1:0] != 2'b00) return '0;
        if (a < 8'h80) begin
            if (RESV[a[6:2]]) return m_res[a[6:2]];
            return {28'd0, m_s2[a[6:2]*SW +: SW]};
        end
        if (a == 8'h80) return {27'd0, m_sel};
        if (a == 8'h84) return m_req;
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of outputs (R10, R8)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R10 irq_out vs model", irq, m_req);
            chk("R8 nmi_out vs model", {31'd0, nmi}, {31'd0, m_nmi});
        end
    end

    always @(posedge clk) begin
        if (cyc == 20000) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=%0d expected=<20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        #1; addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        #1; we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        #1; addr = a;
        #1; chk(tag, rdata, m_read(a));
    endtask

    task automatic rdx(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        #1; addr = a;
        #1; chk(tag, rdata, exp);
        chk({tag, " model"}, m_read(a), exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        #1 rst = 1'b0;
        // R1: reset state
        rdx(8'h84, 32'h0, "R1 request reg after reset");
        rdx(8'h80, 32'h0, "R1 select reg after reset");
        rdx(8'h10, 32'h0, "R1 identity slot after reset");
        rdx(8'h40, 32'h0, "R1 reserved slot after reset");

        // R5 set, R10 readback
        wr(8'h84, 32'h0000_0008);
        rdx(8'h84, 32'h0000_0008, "R5 software set bit 3");
        // R6 clear and write-zero
        wr(8'h84, 32'h0000_0009);
        rdx(8'h84, 32'h0000_0001, "R6 toggle clears 3 sets 0");
        wr(8'h84, 32'h0);
        rdx(8'h84, 32'h0000_0001, "R6 write zero no effect");
        wr(8'h84, 32'h0000_0001);
        rdx(8'h84, 32'h0, "R6 clear bit 0");

        // R2/R3: line 4 with sub-source 1, line 6 with all four
        @(negedge clk); #1 sub[4*SW +: SW] = 4'b0010; sub[6*SW +: SW] = 4'b1111;
        idle(3);
        rdx(8'h10, 32'h2, "R2 identity line 4");
        rdx(8'h18, 32'hF, "R2 identity line 6");
        rdx(8'h84, 32'h0000_0050, "R3 lines 4 and 6 set");
        wr(8'h14, 32'hFFFF_FFFF);
        rdx(8'h14, 32'h0, "R2 identity write ignored");

        // R7: clear while hardware still requesting
        wr(8'h84, 32'h0000_0010);
        rdx(8'h84, 32'h0000_0050, "R7 hardware wins over clear");
        @(negedge clk); #1 sub = '0;
        idle(4);
        wr(8'h84, 32'h0000_0050);
        rdx(8'h84, 32'h0, "R3 cleared after request drops");

        // R4: reserved slot storage and ignored inputs
        wr(8'h40, 32'hDEAD_BEEF);
        rdx(8'h40, 32'hDEAD_BEEF, "R4 reserved slot readback");
        @(negedge clk); #1 sub[16*SW +: SW] = 4'b1111; sub[31*SW +: SW] = 4'b0001;
        idle(4);
        rdx(8'h84, 32'h0, "R4 reserved inputs set nothing");
        rdx(8'h40, 32'hDEAD_BEEF, "R4 reserved slot unchanged");
        rdx(8'h7C, 32'h0, "R4 reserved slot 31 zero");
        @(negedge clk); #1 sub = '0;

        // R8: select and nmi path
        wr(8'h80, 32'hFFFF_FFE5);
        rdx(8'h80, 32'h5, "R8 select field truncated");
        wr(8'h84, 32'h0000_0020);
        idle(2);
        chk("R8 nmi high on selected bit", {31'd0, nmi}, 32'h1);
        wr(8'h84, 32'h0000_0020);
        idle(2);
        chk("R8 nmi low after clear", {31'd0, nmi}, 32'h0);
        @(negedge clk); #1 sub[29*SW +: SW] = 4'b0001;
        wr(8'h80, 32'd29);
        idle(4);
        chk("R8 nmi from hardware line 29", {31'd0, nmi}, 32'h1);
        @(negedge clk); #1 sub = '0;
        idle(3);
        wr(8'h84, 32'h2000_0000);
        idle(2);

        // R9: out-of-range and unaligned
        wr(8'h88, 32'hFFFF_FFFF);
        wr(8'h85, 32'hFFFF_FFFF);
        wr(8'h41, 32'h1234_5678);
        rdx(8'h84, 32'h0, "R9 stray writes leave request reg");
        rdx(8'h40, 32'hDEAD_BEEF, "R9 unaligned write ignored");
        rdx(8'h88, 32'h0, "R9 read 0x88");
        rdx(8'hFC, 32'h0, "R9 read 0xFC");
        rdx(8'h86, 32'h0, "R9 unaligned read");
        rd(8'h80, "R9 select unchanged");

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule